// File: doc/BRIEF.md
# Clock Mode Controller with Settled Status

This block is the digital control side of a clock generator that can run from an FLL, a PLL, an internal reference or an external reference. Software programs a control register with a source select, a reference select, a PLL select, a low-power bypass bit and an external-reference enable. It programs a second register with the FLL range, a high-multiplier bit and a reference divider code. From these fields the block works out which of eight operating modes is active. It drives the select of the output clock multiplexer and the FLL multiplication factor, and it divides the reference divider code into a ratio.

Each selection that moves an analog source has a read-only status copy. A status copy takes the value of its control field only once that field has held steady for a settling period of `SETTLE` cycles. This settling period stands in for lock or start-up time. Software polls the status register before it makes the next change. The mode decode and the multiplexer select follow the settled status, so the output clock never switches to a source that has not finished settling.

The block also gives a bus clock enable that is high on every second cycle. It raises a flag while the control fields ask for the PLL but the PLL status is still clear.

Top module: `clkmode_ctrl`

## Requirements
- R1: After reset, the control register (address 0) reads 0x04 and the status register (address 2) reads 0x04. The mode output is 0 (FLL, internal reference) and the multiplexer select is 0 (FLL).
- R2: The control register at address 0 holds: bits [1:0] source select (00 FLL/PLL, 01 internal, 10 external), bit 2 internal-reference select, bit 3 PLL select, bit 4 low-power bypass, bit 5 external-reference enable. The tuning register at address 1 holds: bit 0 range, bit 1 high multiplier, bits [4:2] reference divider code. Bits that are not listed read 0, and address 3 reads 0.
- R3: The status register holds: bits [1:0] source status, bit 2 reference status, bit 3 PLL status, bit 4 oscillator ready. These bits follow the source select, internal-reference select, PLL select and external-reference enable. A status field takes its control value at the (SETTLE+1)-th rising edge after the edge that captured the write.
- R4: If a control field changes value before its settle completes, the count restarts from the new write. A value that was overwritten before it settled never appears in the status. If the field changes at the very edge where its settle completes, the older value lands first and the new value then settles in full.
- R5: Writes to address 2 have no effect. In a write to address 0 whose bits [1:0] are 11, the source select keeps its old value, and the other fields of that write still take effect.
- R6: A write to address 1 leaves the range bit unchanged while the low-power bit or the PLL select bit is 1. The other tuning fields are still written.
- R7: The FLL factor output is 512 when range=0 and 1024 when range=1. With the high-multiplier bit set, these become 608 and 1216.
- R8: The reference divide ratio output equals 2 to the power of the divider code (001 gives 2, 010 gives 4).
- R9: The mode output is decoded from the settled status and the low-power bit. The encodings are: 0 FLL internal, 1 FLL external, 2 bypass internal, 3 bypass external, 4 PLL external, 5 PLL-bypass external, 6 low-power internal, 7 low-power external. With source status 00, the mode is 4 when PLL status is 1, otherwise 0 when reference status is 1, otherwise 1. With source status 01, the mode is 6 when low-power is 1, otherwise 2. With source status 10, the mode is 7 when low-power is 1, otherwise 5 when PLL status is 1, otherwise 3.
- R10: The multiplexer select is 0 (FLL) for modes 0 and 1, 1 (PLL) for mode 4, 2 (internal) for modes 2 and 6, and 3 (external) for modes 3, 5 and 7.
- R11: The bus clock enable is 0 in reset and then alternates 1, 0, 1, ... on each cycle.
- R12: The pending flag is 1 exactly when the source select is 00, the PLL select is 1 and the PLL status is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| mode_o | output | 3 | Decoded operating mode |
| clk_sel_o | output | 2 | Output clock multiplexer select |
| fll_mult_o | output | 11 | FLL multiplication factor |
| ref_div_o | output | 8 | Reference divide ratio |
| bus_ce_o | output | 1 | Bus clock enable, half rate |
| pll_pend_o | output | 1 | PLL requested but not yet settled |

## Verification
A status field can finish settling in the same cycle that a new write changes its control field. The bench provokes this in two ways. First, it writes a new source select exactly SETTLE+1 edges after the previous one, so the old value must land and the new one must then take another full period. Second, it writes one edge earlier, where the restart must win and the status must not move at all. The behavioural model counts the age of each field in edges, independently of the settle state machine, and the bench compares status, mode and select against that model on every cycle.

// File: rtl/clkmode_pkg.sv
`timescale 1ns/1ps
package clkmode_pkg;

    typedef enum logic [2:0] {
        MODE_FLL_INT    = 3'd0,
        MODE_FLL_EXT    = 3'd1,
        MODE_BYP_INT    = 3'd2,
        MODE_BYP_EXT    = 3'd3,
        MODE_PLL_EXT    = 3'd4,
        MODE_PLLBYP_EXT = 3'd5,
        MODE_LP_INT     = 3'd6,
        MODE_LP_EXT     = 3'd7
    } clk_mode_e;

    typedef enum logic [1:0] {
        SEL_FLL = 2'd0,
        SEL_PLL = 2'd1,
        SEL_INT = 2'd2,
        SEL_EXT = 2'd3
    } clk_sel_e;

    typedef struct packed {
        logic       xref_en;
        logic       lowpwr;
        logic       pll_sel;
        logic       iref_sel;
        logic [1:0] src;
    } ctrl_t;

    localparam int ADDR_CTRL = 0;
    localparam int ADDR_TUNE = 1;
    localparam int ADDR_STAT = 2;

endpackage

// File: rtl/clkmode_settle.sv
`timescale 1ns/1ps
module clkmode_settle #(
    parameter int             W       = 1,
    parameter int             SETTLE  = 8,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ctrl_i,
    output logic [W-1:0] stat_o
);
    localparam int CW = $clog2(SETTLE + 1);

    typedef enum logic {ST_STABLE, ST_SETTLING} settle_e;

    settle_e       state_q, state_d;
    logic [W-1:0]  tgt_q, tgt_d;
    logic [W-1:0]  st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STABLE;
            tgt_q   <= RST_VAL;
            st_q    <= RST_VAL;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            tgt_q   <= tgt_d;
            st_q    <= st_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        tgt_d   = tgt_q;
        st_d    = st_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_STABLE: begin
                if (ctrl_i != st_q) begin
                    tgt_d   = ctrl_i;
                    cnt_d   = '0;
                    state_d = ST_SETTLING;
                end
            end
            ST_SETTLING: begin
                if (ctrl_i != tgt_q) begin
                    tgt_d = ctrl_i;
                    cnt_d = '0;
                    if (ctrl_i == st_q) state_d = ST_STABLE;
                end else if (cnt_q == CW'(SETTLE - 1)) begin
                    st_d    = tgt_q;
                    state_d = ST_STABLE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
        endcase
    end

    assign stat_o = st_q;

    // R3
    status_follows_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != $past(st_q)) |-> (st_q == $past(ctrl_i)));

    // R4
    restart_no_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLING && ctrl_i != tgt_q) |=> $stable(st_q));

endmodule

// File: rtl/clkmode_regs.sv
`timescale 1ns/1ps
module clkmode_regs
    import clkmode_pkg::*;
#(
    parameter int AW = 2,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_i,
    input  logic          we_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [DW-1:0] stat_i,
    output ctrl_t         ctrl_o,
    output logic          range_o,
    output logic          himul_o,
    output logic [2:0]    rdiv_o,
    output logic [DW-1:0] rdata_o
);
    ctrl_t      ctrl_q;
    logic       range_q, himul_q;
    logic [2:0] rdiv_q;
    logic       wdata_unused;

    assign wdata_unused = ^wdata_i[DW-1:6];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '{xref_en: 1'b0, lowpwr: 1'b0, pll_sel: 1'b0,
                         iref_sel: 1'b1, src: 2'b00};
            range_q <= 1'b0;
            himul_q <= 1'b0;
            rdiv_q  <= '0;
        end else if (we_i) begin
            if (addr_i == AW'(ADDR_CTRL)) begin
                if (wdata_i[1:0] != 2'b11) ctrl_q.src <= wdata_i[1:0];
                ctrl_q.iref_sel <= wdata_i[2];
                ctrl_q.pll_sel  <= wdata_i[3];
                ctrl_q.lowpwr   <= wdata_i[4];
                ctrl_q.xref_en  <= wdata_i[5];
            end else if (addr_i == AW'(ADDR_TUNE)) begin
                if (!(ctrl_q.lowpwr || ctrl_q.pll_sel)) range_q <= wdata_i[0];
                himul_q <= wdata_i[1];
                rdiv_q  <= wdata_i[4:2];
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == AW'(ADDR_CTRL))      rdata_o = DW'(ctrl_q);
        else if (addr_i == AW'(ADDR_TUNE)) rdata_o = DW'({rdiv_q, himul_q, range_q});
        else if (addr_i == AW'(ADDR_STAT)) rdata_o = stat_i;
    end

    assign ctrl_o  = ctrl_q;
    assign range_o = range_q;
    assign himul_o = himul_q;
    assign rdiv_o  = rdiv_q;

    // R6
    range_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == AW'(ADDR_TUNE) && (ctrl_q.lowpwr || ctrl_q.pll_sel))
        |=> (range_q == $past(range_q)));

    // R5
    src_code3_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == AW'(ADDR_CTRL) && wdata_i[1:0] == 2'b11)
        |=> (ctrl_q.src == $past(ctrl_q.src)));

endmodule

// File: rtl/clkmode_decode.sv
`timescale 1ns/1ps
module clkmode_decode
    import clkmode_pkg::*;
(
    input  logic [1:0] src_st_i,
    input  logic       iref_st_i,
    input  logic       pll_st_i,
    input  logic       lowpwr_i,
    output clk_mode_e  mode_o,
    output clk_sel_e   sel_o
);
    always_comb begin
        unique case (src_st_i)
            2'b01:   mode_o = lowpwr_i ? MODE_LP_INT : MODE_BYP_INT;
            2'b10:   mode_o = lowpwr_i ? MODE_LP_EXT :
                              (pll_st_i ? MODE_PLLBYP_EXT : MODE_BYP_EXT);
            default: mode_o = pll_st_i ? MODE_PLL_EXT :
                              (iref_st_i ? MODE_FLL_INT : MODE_FLL_EXT);
        endcase
    end

    always_comb begin
        unique case (mode_o)
            MODE_FLL_INT, MODE_FLL_EXT:                  sel_o = SEL_FLL;
            MODE_PLL_EXT:                                sel_o = SEL_PLL;
            MODE_BYP_INT, MODE_LP_INT:                   sel_o = SEL_INT;
            MODE_BYP_EXT, MODE_PLLBYP_EXT, MODE_LP_EXT:  sel_o = SEL_EXT;
        endcase
    end

endmodule

// File: rtl/clkmode_ctrl.sv
`timescale 1ns/1ps
module clkmode_ctrl
    import clkmode_pkg::*;
#(
    parameter int SETTLE    = 8,
    parameter int MULT_W    = 11,
    parameter int MULT_LO   = 512,
    parameter int MULT_HI   = 1024,
    parameter int MULT_LO_X = 608,
    parameter int MULT_HI_X = 1216,
    parameter int DIV_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_we,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic [2:0]        mode_o,
    output logic [1:0]        clk_sel_o,
    output logic [MULT_W-1:0] fll_mult_o,
    output logic [DIV_W-1:0]  ref_div_o,
    output logic              bus_ce_o,
    output logic              pll_pend_o
);
    localparam int         NBIT    = 3;
    localparam logic [2:0] BIT_RST = 3'b001;

    ctrl_t      ctrl;
    logic       range_q, himul_q;
    logic [2:0] rdiv_q;
    logic [1:0] src_st;
    logic [NBIT-1:0] bit_ctrl, bit_st;
    logic [7:0] stat_word;
    clk_mode_e  mode;
    clk_sel_e   sel;
    logic       ce_q;

    clkmode_regs #(.AW(2), .DW(8)) regs_i (
        .clk(clk), .rst_n(rst_n), .addr_i(bus_addr), .we_i(bus_we),
        .wdata_i(bus_wdata), .stat_i(stat_word), .ctrl_o(ctrl),
        .range_o(range_q), .himul_o(himul_q), .rdiv_o(rdiv_q),
        .rdata_o(bus_rdata)
    );

    // bit 0 reference, bit 1 PLL, bit 2 oscillator
    assign bit_ctrl = {ctrl.xref_en, ctrl.pll_sel, ctrl.iref_sel};

    generate
        for (genvar i = 0; i < NBIT; i++) begin : g_bit_settle
            clkmode_settle #(.W(1), .SETTLE(SETTLE), .RST_VAL(BIT_RST[i])) settle_i (
                .clk(clk), .rst_n(rst_n), .ctrl_i(bit_ctrl[i]), .stat_o(bit_st[i])
            );
        end
    endgenerate

    clkmode_settle #(.W(2), .SETTLE(SETTLE), .RST_VAL(2'b00)) src_settle_i (
        .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl.src), .stat_o(src_st)
    );

    assign stat_word = {3'b000, bit_st[2], bit_st[1], bit_st[0], src_st};

    clkmode_decode decode_i (
        .src_st_i(src_st), .iref_st_i(bit_st[0]), .pll_st_i(bit_st[1]),
        .lowpwr_i(ctrl.lowpwr), .mode_o(mode), .sel_o(sel)
    );

    assign mode_o    = mode;
    assign clk_sel_o = sel;

    always_comb begin
        if (himul_q) fll_mult_o = range_q ? MULT_W'(MULT_HI_X) : MULT_W'(MULT_LO_X);
        else         fll_mult_o = range_q ? MULT_W'(MULT_HI)   : MULT_W'(MULT_LO);
    end

    assign ref_div_o  = DIV_W'(1) << rdiv_q;
    assign pll_pend_o = (ctrl.src == 2'b00) && ctrl.pll_sel && !bit_st[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ce_q <= 1'b0;
        else        ce_q <= !ce_q;
    end
    assign bus_ce_o = ce_q;

    // R11
    bus_ce_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ce_o |=> !bus_ce_o);

    // R11
    bus_ce_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_ce_o && $past(rst_n)) |=> bus_ce_o);

    // R12
    pend_not_pll_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pll_pend_o |-> (mode_o != 3'(MODE_PLL_EXT)));

    // R10
    pll_mode_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'(MODE_PLL_EXT)) |-> (clk_sel_o == 2'(SEL_PLL)));

endmodule

// File: tb/clkmode_ctrl_tb_top.sv
`timescale 1ns/1ps
module clkmode_ctrl_tb_top;
    localparam int S   = 8;
    localparam int SAT = 1000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [2:0] mode_o;
    logic [1:0] clk_sel_o;
    logic [10:0] fll_mult_o;
    logic [7:0] ref_div_o;
    logic       bus_ce_o, pll_pend_o;

    int errors = 0;
    int checks = 0;
    bit cmp_en = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    clkmode_ctrl #(.SETTLE(S)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mode_o(mode_o),
        .clk_sel_o(clk_sel_o), .fll_mult_o(fll_mult_o), .ref_div_o(ref_div_o),
        .bus_ce_o(bus_ce_o), .pll_pend_o(pll_pend_o)
    );

    // behavioural reference model
    int m_src, m_iref, m_pll, m_lp, m_xref, m_range, m_hi, m_rdiv;
    int s_src, s_iref, s_pll, s_osc;
    int a_src, a_iref, a_pll, a_osc;
    int m_ce;

    function automatic int age_next(int age, bit changed);
        if (changed) return 0;
        return (age < SAT) ? age + 1 : SAT;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_src = 0; m_iref = 1; m_pll = 0; m_lp = 0; m_xref = 0;
            m_range = 0; m_hi = 0; m_rdiv = 0;
            s_src = 0; s_iref = 1; s_pll = 0; s_osc = 0;
            a_src = SAT; a_iref = SAT; a_pll = SAT; a_osc = SAT;
            m_ce = 0;
        end else begin
            int o_src, o_iref, o_pll, o_xref;
            if (a_src + 1 == S + 1)  s_src  = m_src;
            if (a_iref + 1 == S + 1) s_iref = m_iref;
            if (a_pll + 1 == S + 1)  s_pll  = m_pll;
            if (a_osc + 1 == S + 1)  s_osc  = m_xref;
            o_src = m_src; o_iref = m_iref; o_pll = m_pll; o_xref = m_xref;
            if (bus_we && bus_addr == 2'd0) begin
                if (bus_wdata[1:0] != 2'b11) m_src = int'(bus_wdata[1:0]);
                m_iref = int'(bus_wdata[2]);
                m_pll  = int'(bus_wdata[3]);
                m_lp   = int'(bus_wdata[4]);
                m_xref = int'(bus_wdata[5]);
            end else if (bus_we && bus_addr == 2'd1) begin
                if (m_lp == 0 && m_pll == 0) m_range = int'(bus_wdata[0]);
                m_hi   = int'(bus_wdata[1]);
                m_rdiv = int'(bus_wdata[4:2]);
            end
            a_src  = age_next(a_src,  m_src  != o_src);
            a_iref = age_next(a_iref, m_iref != o_iref);
            a_pll  = age_next(a_pll,  m_pll  != o_pll);
            a_osc  = age_next(a_osc,  m_xref != o_xref);
            m_ce = 1 - m_ce;
        end
    end

    function automatic int exp_mode();
        if (s_src == 1) return (m_lp != 0) ? 6 : 2;
        if (s_src == 2) begin
            if (m_lp != 0) return 7;
            return (s_pll != 0) ? 5 : 3;
        end
        if (s_pll != 0) return 4;
        return (s_iref != 0) ? 0 : 1;
    endfunction

    function automatic int exp_sel(int md);
        case (md)
            0, 1:    return 0;
            4:       return 1;
            2, 6:    return 2;
            default: return 3;
        endcase
    endfunction

    function automatic int exp_rdata(int a);
        case (a)
            0: return m_src + 4 * m_iref + 8 * m_pll + 16 * m_lp + 32 * m_xref;
            1: return m_range + 2 * m_hi + 4 * m_rdiv;
            2: return s_src + 4 * s_iref + 8 * s_pll + 16 * s_osc;
            default: return 0;
        endcase
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            int md;
            md = exp_mode();
            check("R9", int'(mode_o), md);
            check("R10", int'(clk_sel_o), exp_sel(md));
            check("R7", int'(fll_mult_o),
                  (m_hi != 0) ? ((m_range != 0) ? 1216 : 608) : ((m_range != 0) ? 1024 : 512));
            check("R8", int'(ref_div_o), 1 << m_rdiv);
            check("R11", int'(bus_ce_o), m_ce);
            check("R12", int'(pll_pend_o), (m_src == 0 && m_pll != 0 && s_pll == 0) ? 1 : 0);
            check((bus_addr == 2'd2) ? "R3" : "R2", int'(bus_rdata), exp_rdata(int'(bus_addr)));
        end
    end

    task automatic next();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        next();
        bus_we = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            bus_addr = 2'(i % 3);
            next();
        end
    endtask

    task automatic peek(input logic [1:0] a, input string req, input int exp);
        bus_addr = a;
        @(negedge clk);
        check(req, int'(bus_rdata), exp);
        next();
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: requirement all, actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        cmp_en = 1'b1;
        // R1 reset state
        @(negedge clk);
        check("R1", int'(mode_o), 0);
        check("R1", int'(clk_sel_o), 0);
        next();
        peek(2'd0, "R1", 8'h04);
        peek(2'd2, "R1", 8'h04);

        // R7 / R8 tuning field patterns
        wr(2'd1, 8'h05);
        peek(2'd1, "R2", 8'h05);
        @(negedge clk);
        check("R7", int'(fll_mult_o), 1024);
        check("R8", int'(ref_div_o), 2);
        next();
        wr(2'd1, 8'h0A);
        @(negedge clk);
        check("R7", int'(fll_mult_o), 608);
        check("R8", int'(ref_div_o), 4);
        next();
        wr(2'd1, 8'h0B);
        @(negedge clk);
        check("R7", int'(fll_mult_o), 1216);
        next();

        // R3 settle timing to bypass external
        wr(2'd0, 8'h22);
        idle(S - 1);
        peek(2'd2, "R3", 8'h04);
        peek(2'd2, "R3", 8'h04);
        peek(2'd2, "R3", 8'h12);
        @(negedge clk);
        check("R9", int'(mode_o), 3);
        check("R10", int'(clk_sel_o), 3);
        next();

        // R4 restart: overwritten source value never shows
        wr(2'd0, 8'h21);
        idle(4);
        wr(2'd0, 8'h20);
        idle(4);
        peek(2'd2, "R4", 8'h12);
        idle(3);
        peek(2'd2, "R4", 8'h12);
        peek(2'd2, "R4", 8'h10);
        @(negedge clk);
        check("R9", int'(mode_o), 1);
        next();

        // R4 collision: rewrite at the completing edge
        wr(2'd0, 8'h25);
        idle(S);
        wr(2'd0, 8'h26);
        peek(2'd2, "R4", 8'h15);
        idle(S - 1);
        peek(2'd2, "R4", 8'h15);
        peek(2'd2, "R4", 8'h16);

        // R4 rewrite one edge before completion, back to settled value
        wr(2'd0, 8'h24);
        idle(S - 1);
        wr(2'd0, 8'h26);
        peek(2'd2, "R4", 8'h16);
        idle(S + 2);
        peek(2'd2, "R4", 8'h16);

        // R6 range locked under low power, then under PLL select
        wr(2'd0, 8'h36);
        @(negedge clk);
        check("R9", int'(mode_o), 7);
        next();
        wr(2'd1, 8'h0A);
        peek(2'd1, "R6", 8'h0B);
        wr(2'd0, 8'h26);
        wr(2'd1, 8'h0A);
        peek(2'd1, "R6", 8'h0A);
        wr(2'd0, 8'h2E);
        wr(2'd1, 8'h0B);
        peek(2'd1, "R6", 8'h0A);
        idle(S + 2);
        peek(2'd2, "R3", 8'h1E);
        @(negedge clk);
        check("R9", int'(mode_o), 5);
        next();

        // R12 pending flag around a PLL engage
        wr(2'd0, 8'h26);
        idle(S + 2);
        wr(2'd0, 8'h28);
        @(negedge clk);
        check("R12", int'(pll_pend_o), 1);
        next();
        idle(S + 2);
        @(negedge clk);
        check("R12", int'(pll_pend_o), 0);
        check("R9", int'(mode_o), 4);
        check("R10", int'(clk_sel_o), 1);
        next();

        // low-power internal
        wr(2'd0, 8'h15);
        idle(S + 2);
        peek(2'd2, "R3", 8'h05);
        @(negedge clk);
        check("R9", int'(mode_o), 6);
        check("R10", int'(clk_sel_o), 2);
        next();

        // R5 ignored writes
        wr(2'd2, 8'hFF);
        peek(2'd2, "R5", 8'h05);
        wr(2'd0, 8'h07);
        peek(2'd0, "R5", 8'h05);
        idle(S + 2);
        peek(2'd2, "R5", 8'h05);
        @(negedge clk);
        check("R9", int'(mode_o), 2);
        next();

        // R2 unused address, R11 alternation
        peek(2'd3, "R2", 0);
        begin
            int v;
            @(negedge clk);
            v = int'(bus_ce_o);
            next();
            @(negedge clk);
            check("R11", int'(bus_ce_o), 1 - v);
            next();
        end
        idle(4);
        finish_run();
    end
endmodule